// File: doc/BRIEF.md
# Eight-Operation Two-Bit ALU

This block is a combinational arithmetic-logic unit for two small unsigned operands, A and B. A 3-bit operation code selects one of eight functions: addition, subtraction, bitwise AND, bitwise OR, inversion, a one-place shift in either direction, and a magnitude comparison. Each function produces a result word as wide as the operands and one auxiliary flag bit. The flag carries the carry-out for addition, the borrow for subtraction, the bit lost in a shift, and the equality outcome for a comparison.

The opcode map is fixed and is not in sequence. The compare sits at code zero and the add at code seven, and the other six functions fill the codes in between. The block has no clock and holds no state. A surrounding datapath registers the operands and the result as it needs. The operand width is a parameter. The default is two bits, and the opcode map and the flag rules stay the same at any width of two or more.

Top module: `alu2_top`

## Requirements
- R1: With op_sel = 3'b111, res_out = (A + B) mod 4 and aux_flag is the carry-out, set exactly when A + B >= 4.
- R2: With op_sel = 3'b001, res_out = (A - B) mod 4 and aux_flag is the borrow, set exactly when A < B.
- R3: With op_sel = 3'b100, res_out = A & B and aux_flag = 0.
- R4: With op_sel = 3'b101, res_out = A | B and aux_flag = 0.
- R5: With op_sel = 3'b110, res_out = ~A and aux_flag = 0, whatever the value of B.
- R6: With op_sel = 3'b010, res_out = {A[0], 0} and aux_flag = A[1]. The value of B has no effect.
- R7: With op_sel = 3'b011, res_out = {0, A[1]} and aux_flag = A[0]. The value of B has no effect.
- R8: With op_sel = 3'b000, res_out[1] = (A > B), res_out[0] = (A < B) and aux_flag = (A == B), so exactly one of the three bits is set.
- R9: The outputs depend only on the present inputs, and every one of the 128 input combinations gives a defined result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 2 | Operand A, unsigned |
| b_in | input | 2 | Operand B, unsigned |
| op_sel | input | 3 | Operation code |
| res_out | output | 2 | Result word |
| aux_flag | output | 1 | Carry, borrow, shifted-out bit or equality flag |

## Verification
The assertions are re-evaluated whenever an input changes. They check that an add or subtract result, when inverted, gives back operand A, that the three compare bits are exactly one-hot, that the logic operations keep the flag at zero, and that a shift clears the vacated bit. The bench shows the rest by sweeping every operand pair under every opcode. That sweep covers the exact carry and borrow boundaries, the bit that moves into the flag on a shift, and the operations where B must have no effect.

// File: rtl/alu2_pkg.sv
package alu2_pkg;
  typedef enum logic [2:0] {
    OP_CMP = 3'b000,
    OP_SUB = 3'b001,
    OP_SHL = 3'b010,
    OP_SHR = 3'b011,
    OP_AND = 3'b100,
    OP_OR  = 3'b101,
    OP_NOT = 3'b110,
    OP_ADD = 3'b111
  } alu_op_e;
endpackage

// File: rtl/alu2_addsub.sv
module alu2_addsub #(
  parameter int W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic [W-1:0] diff,
  output logic         borrow
);
  logic [W:0] add_wide;
  logic [W:0] sub_wide;

  always_comb begin
    add_wide = {1'b0, a} + {1'b0, b};
    // subtract as A + ~B + 1; carry-out clear means a borrow occurred
    sub_wide = {1'b0, a} + {1'b0, ~b} + {{W{1'b0}}, 1'b1};
    sum      = add_wide[W-1:0];
    carry    = add_wide[W];
    diff     = sub_wide[W-1:0];
    borrow   = ~sub_wide[W];
  end
endmodule

// File: rtl/alu2_bitwise.sv
module alu2_bitwise #(
  parameter int W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] inv_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign and_o[i] = a[i] & b[i];
    assign or_o[i]  = a[i] | b[i];
    assign inv_o[i] = ~a[i];
  end
endmodule

// File: rtl/alu2_shift.sv
module alu2_shift #(
  parameter int W = 2
) (
  input  logic [W-1:0] a,
  output logic [W-1:0] shl_o,
  output logic         shl_out,
  output logic [W-1:0] shr_o,
  output logic         shr_out
);
  assign shl_o   = {a[W-2:0], 1'b0};
  assign shl_out = a[W-1];
  assign shr_o   = {1'b0, a[W-1:1]};
  assign shr_out = a[0];
endmodule

// File: rtl/alu2_cmp.sv
module alu2_cmp #(
  parameter int W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         gt,
  output logic         lt,
  output logic         eq
);
  // ripple from LSB: the highest differing bit decides
  logic [W:0] gt_c;
  logic [W:0] lt_c;
  assign gt_c[0] = 1'b0;
  assign lt_c[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_stage
    assign gt_c[i+1] = (a[i] & ~b[i]) | (~(a[i] ^ b[i]) & gt_c[i]);
    assign lt_c[i+1] = (~a[i] & b[i]) | (~(a[i] ^ b[i]) & lt_c[i]);
  end
  assign gt = gt_c[W];
  assign lt = lt_c[W];
  assign eq = ~(gt_c[W] | lt_c[W]);
endmodule

// File: rtl/alu2_top.sv
module alu2_top
  import alu2_pkg::*;
#(
  parameter int W = 2
) (
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic [2:0]   op_sel,
  output logic [W-1:0] res_out,
  output logic         aux_flag
);
  localparam logic [W-1:0] ZERO_W = '0;

  logic [W-1:0] sum_w, diff_w, and_w, or_w, inv_w, shl_w, shr_w;
  logic         carry_w, borrow_w, shl_f, shr_f, gt_w, lt_w, eq_w;
  alu_op_e      op;

  assign op = alu_op_e'(op_sel);

  alu2_addsub #(.W(W)) u_addsub (
    .a(a_in), .b(b_in), .sum(sum_w), .carry(carry_w),
    .diff(diff_w), .borrow(borrow_w)
  );

  alu2_bitwise #(.W(W)) u_bitwise (
    .a(a_in), .b(b_in), .and_o(and_w), .or_o(or_w), .inv_o(inv_w)
  );

  alu2_shift #(.W(W)) u_shift (
    .a(a_in), .shl_o(shl_w), .shl_out(shl_f), .shr_o(shr_w), .shr_out(shr_f)
  );

  alu2_cmp #(.W(W)) u_cmp (
    .a(a_in), .b(b_in), .gt(gt_w), .lt(lt_w), .eq(eq_w)
  );

  always_comb begin
    res_out  = ZERO_W;
    aux_flag = 1'b0;
    case (op)
      OP_ADD: begin res_out = sum_w;  aux_flag = carry_w;  end
      OP_SUB: begin res_out = diff_w; aux_flag = borrow_w; end
      OP_AND: res_out = and_w;
      OP_OR:  res_out = or_w;
      OP_NOT: res_out = inv_w;
      OP_SHL: begin res_out = shl_w;  aux_flag = shl_f;    end
      OP_SHR: begin res_out = shr_w;  aux_flag = shr_f;    end
      default: begin
        res_out    = ZERO_W;
        res_out[1] = gt_w;
        res_out[0] = lt_w;
        aux_flag   = eq_w;
      end
    endcase
  end

  always_comb begin
    if (op == OP_ADD) begin
      // R1
      add_inverse_chk: assert (W'(res_out - b_in) == a_in);
    end
    if (op == OP_SUB) begin
      // R2
      sub_inverse_chk: assert (W'(res_out + b_in) == a_in);
      // R2
      sub_borrow_chk: assert (aux_flag == lt_w);
    end
    if (op == OP_AND || op == OP_OR || op == OP_NOT) begin
      // R3
      logic_flag_zero_chk: assert (aux_flag == 1'b0);
    end
    if (op == OP_SHL) begin
      // R6
      shl_fill_chk: assert (res_out[0] == 1'b0);
    end
    if (op == OP_SHR) begin
      // R7
      shr_fill_chk: assert (res_out[W-1] == 1'b0);
    end
    if (op == OP_CMP) begin
      // R8
      cmp_onehot_chk: assert ($countones({res_out[1:0], aux_flag}) == 1);
    end
  end
endmodule

// File: tb/tb_alu2_top.sv
module tb_alu2_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 200000;

  logic       clk = 1'b0;
  logic [1:0] a_in, b_in;
  logic [2:0] op_sel;
  logic [1:0] res_out;
  logic       aux_flag;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu2_top dut (
    .a_in(a_in), .b_in(b_in), .op_sel(op_sel),
    .res_out(res_out), .aux_flag(aux_flag)
  );

  task automatic expect_val(input int a, input int b, input int s,
                            output int er, output int ef, output string tag);
    case (s)
      7: begin er = (a + b) % 4; ef = (a + b >= 4) ? 1 : 0; tag = "R1 add"; end
      1: begin er = (a - b + 4) % 4; ef = (a < b) ? 1 : 0; tag = "R2 sub"; end
      4: begin er = a & b; ef = 0; tag = "R3 and"; end
      5: begin er = a | b; ef = 0; tag = "R4 or"; end
      6: begin er = 3 - a; ef = 0; tag = "R5 not"; end
      2: begin er = (a * 2) % 4; ef = a / 2; tag = "R6 shl"; end
      3: begin er = a / 2; ef = a % 2; tag = "R7 shr"; end
      default: begin
        er = ((a > b) ? 2 : 0) + ((a < b) ? 1 : 0);
        ef = (a == b) ? 1 : 0;
        tag = "R8 cmp";
      end
    endcase
  endtask

  initial begin
    int er, ef;
    string tag;
    a_in = 2'd0; b_in = 2'd0; op_sel = 3'd0;
    @(negedge clk);
    // R9: defined result right after start, no clock needed
    checks++;
    if (res_out !== 2'b00 || aux_flag !== 1'b1) begin
      fails++;
      $display("FAIL R9 initial: got %b/%b expected 00/1", res_out, aux_flag);
    end
    for (int s = 0; s < 8; s++) begin
      for (int a = 0; a < 4; a++) begin
        for (int b = 0; b < 4; b++) begin
          @(negedge clk);
          a_in = 2'(a); b_in = 2'(b); op_sel = 3'(s);
          @(posedge clk);
          expect_val(a, b, s, er, ef, tag);
          checks++;
          if (res_out !== 2'(er) || aux_flag !== 1'(ef)) begin
            fails++;
            $display("FAIL %s R9 a=%0d b=%0d: got res=%0d flag=%0d expected res=%0d flag=%0d",
                     tag, a, b, res_out, aux_flag, er, ef);
          end
        end
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog R9: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule